// File: doc/BRIEF.md
# Cyclic Switched-Supply Controller

This block drives the enable of a high-side switched supply that feeds external wake-up switches or small loads. Software writes a two-bit mode. The mode holds the switch permanently off, holds it permanently on, or pulses it in one of two cyclic patterns. Each cyclic pattern opens a short on-window at the start of every period. The wake-up pin is sampled in step with that window, so a switch that is stuck closed costs supply current only for a small fraction of the time.

The analog switch reports overload on a flag. The controller acts on that flag only after it has been seen on consecutive microsecond ticks while the switch is driven. It then drops the mode to Off and raises a sticky interrupt flag if the interrupt is enabled. If the system is asleep at that moment, it also pulses a forced wake-up and latches a reset-source code. That code tells software that the wake path through the switched supply has been lost. All timing runs on a one-cycle tick pulse of 1 µs.

Top module: `swsup_ctrl`

## Requirements
- R1: The mode encodes as 2'b00 Off, 2'b01 On, 2'b10 short cycle and 2'b11 long cycle. A cycle with `mode_wr` high loads `mode_wdata`, which appears on `mode_q` one clock later. `out_en` is low in Off and high in On.
- R2: In a cyclic mode, `out_en` is high for the first ON_WIN ticks of every period and low for the rest. The period is PER_A ticks for 2'b10 and PER_B ticks for 2'b11.
- R3: A write that enters a cyclic mode, or that switches between the two cyclic modes, restarts the period at tick 0. Rewriting the cyclic mode already in force leaves the period position unchanged.
- R4: `wake_evt` is a one-clock pulse in the clock after a qualifying tick on which `wake_pin` (active high) is high. In a cyclic mode, only the last tick of the on-window qualifies. In On, every tick qualifies. In Off, no tick qualifies.
- R5: The overload is confirmed when `ovl_in` is high on OVL_TICKS (default 2) consecutive ticks while `out_en` is high. One clock after confirmation, `mode_q` is 2'b00 and `out_en` is low. A shorter burst has no effect, and neither does an overload while `out_en` is low.
- R6: A confirmed overload sets `irq_flag` only when `irq_en` is high. The flag stays set until `clr_stb`. When a set and a clear fall in the same cycle, the set wins.
- R7: A confirmed overload with `sleep_st` high pulses `wake_force` for one clock and loads `rsrc_code` with 4'h5. The code stays until `clr_stb` returns it to 4'h0. With `sleep_st` low, neither output changes.
- R8: When an overload confirmation and a mode write fall in the same clock, the overload wins and `mode_q` becomes 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-clock pulse every microsecond |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode value to write |
| mode_q | output | 2 | Current mode |
| irq_en | input | 1 | Overload interrupt enable |
| clr_stb | input | 1 | Clears interrupt flag and reset-source code |
| ovl_in | input | 1 | Overload flag from the analog switch |
| wake_pin | input | 1 | Wake-up input, active high |
| sleep_st | input | 1 | High while the system sleeps |
| out_en | output | 1 | Switch enable |
| wake_evt | output | 1 | Wake event pulse |
| irq_flag | output | 1 | Sticky overload interrupt |
| wake_force | output | 1 | Forced wake-up pulse |
| rsrc_code | output | 4 | Sticky reset-source code |

## Verification
Two operations can land on the same clock edge, and each pair is checked. The first pair is overload confirmation and a mode write. The bench arms the filter with one overload tick, then issues the second overload tick in the same cycle as a write to a cyclic mode, and expects `mode_q` to read Off. The second pair is setting the interrupt and clearing it. The bench confirms an overload in the same cycle that `clr_stb` is high, and expects `irq_flag` to stay set.

// File: rtl/swsup_pkg.sv
package swsup_pkg;
   typedef enum logic [1:0] {
      SW_OFF   = 2'b00,
      SW_ON    = 2'b01,
      SW_CYC_A = 2'b10,
      SW_CYC_B = 2'b11
   } sw_mode_e;

   localparam int unsigned RSRC_W = 4;
   localparam logic [RSRC_W-1:0] RSRC_NONE    = 4'h0;
   localparam logic [RSRC_W-1:0] RSRC_SW_LOST = 4'h5;
endpackage

// File: rtl/swsup_cycle_timer.sv
module swsup_cycle_timer
   import swsup_pkg::*;
#(
   parameter int unsigned ON_WIN = 384,
   parameter int unsigned PER_A  = 16000,
   parameter int unsigned PER_B  = 32000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  sw_mode_e mode,
   input  logic     restart,
   output logic     out_on,
   output logic     smp_pt
);
   localparam int unsigned PER_MAX = (PER_A > PER_B) ? PER_A : PER_B;
   localparam int unsigned CW      = $clog2(PER_MAX);
   localparam logic [CW-1:0] WIN_C   = CW'(ON_WIN);
   localparam logic [CW-1:0] LAST_W  = CW'(ON_WIN - 1);
   localparam logic [CW-1:0] LAST_A  = CW'(PER_A - 1);
   localparam logic [CW-1:0] LAST_B  = CW'(PER_B - 1);

   logic [CW-1:0] pos_q;
   logic [CW-1:0] last_pos;
   logic          cyclic;

   assign cyclic   = mode[1];
   assign last_pos = (mode == SW_CYC_B) ? LAST_B : LAST_A;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (restart || !cyclic) begin
         pos_q <= '0;
      end else if (tick) begin
         pos_q <= (pos_q == last_pos) ? '0 : pos_q + 1'b1;
      end
   end

   assign out_on = (mode == SW_ON) || (cyclic && (pos_q < WIN_C));
   assign smp_pt = (mode == SW_ON) || (cyclic && (pos_q == LAST_W));
endmodule

// File: rtl/swsup_ovl_filter.sv
module swsup_ovl_filter #(
   parameter int unsigned OVL_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ovl,
   input  logic armed,
   output logic confirm
);
   logic hit_now;
   assign hit_now = tick && ovl && armed;

   generate
      if (OVL_TICKS == 1) begin : g_direct
         assign confirm = hit_now;
      end else begin : g_count
         localparam int unsigned HW = $clog2(OVL_TICKS);
         localparam logic [HW-1:0] HIT_LAST = HW'(OVL_TICKS - 1);
         logic [HW-1:0] hits_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hits_q <= '0;
            end else if (tick) begin
               if (!(ovl && armed) || (hits_q == HIT_LAST)) hits_q <= '0;
               else                                        hits_q <= hits_q + 1'b1;
            end
         end

         assign confirm = hit_now && (hits_q == HIT_LAST);
      end
   endgenerate
endmodule

// File: rtl/swsup_event_log.sv
module swsup_event_log
   import swsup_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              confirm,
   input  logic              irq_en,
   input  logic              sleep_st,
   input  logic              clr_stb,
   output logic              irq_flag,
   output logic              wake_force,
   output logic [RSRC_W-1:0] rsrc_code
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag   <= 1'b0;
         wake_force <= 1'b0;
         rsrc_code  <= RSRC_NONE;
      end else begin
         wake_force <= confirm && sleep_st;
         if (confirm && irq_en) irq_flag <= 1'b1;
         else if (clr_stb)      irq_flag <= 1'b0;
         if (confirm && sleep_st) rsrc_code <= RSRC_SW_LOST;
         else if (clr_stb)        rsrc_code <= RSRC_NONE;
      end
   end
endmodule

// File: rtl/swsup_ctrl.sv
module swsup_ctrl
   import swsup_pkg::*;
#(
   parameter int unsigned ON_WIN    = 384,
   parameter int unsigned PER_A     = 16000,
   parameter int unsigned PER_B     = 32000,
   parameter int unsigned OVL_TICKS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic       mode_wr,
   input  logic [1:0] mode_wdata,
   output logic [1:0] mode_q,
   input  logic       irq_en,
   input  logic       clr_stb,
   input  logic       ovl_in,
   input  logic       wake_pin,
   input  logic       sleep_st,
   output logic       out_en,
   output logic       wake_evt,
   output logic       irq_flag,
   output logic       wake_force,
   output logic [3:0] rsrc_code
);
   generate
      if (ON_WIN < 1 || ON_WIN >= PER_A || ON_WIN >= PER_B) begin : g_bad_win
         $error("swsup_ctrl: ON_WIN must be at least 1 and shorter than both periods");
      end
      if (OVL_TICKS < 1) begin : g_bad_ovl
         $error("swsup_ctrl: OVL_TICKS must be at least 1");
      end
   endgenerate

   sw_mode_e mode_r;
   sw_mode_e wr_mode;
   logic     confirm;
   logic     restart;
   logic     smp_pt;
   logic     out_on;
   logic     wake_q;

   assign wr_mode = sw_mode_e'(mode_wdata);
   assign restart = mode_wr && wr_mode[1] && (wr_mode != mode_r) && !confirm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r <= SW_OFF;
         wake_q <= 1'b0;
      end else begin
         if (confirm)      mode_r <= SW_OFF;
         else if (mode_wr) mode_r <= wr_mode;
         wake_q <= tick_us && smp_pt && wake_pin;
      end
   end

   swsup_cycle_timer #(
      .ON_WIN (ON_WIN),
      .PER_A  (PER_A),
      .PER_B  (PER_B)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_us),
      .mode    (mode_r),
      .restart (restart),
      .out_on  (out_on),
      .smp_pt  (smp_pt)
   );

   swsup_ovl_filter #(
      .OVL_TICKS (OVL_TICKS)
   ) filt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_us),
      .ovl     (ovl_in),
      .armed   (out_on),
      .confirm (confirm)
   );

   swsup_event_log log_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .confirm    (confirm),
      .irq_en     (irq_en),
      .sleep_st   (sleep_st),
      .clr_stb    (clr_stb),
      .irq_flag   (irq_flag),
      .wake_force (wake_force),
      .rsrc_code  (rsrc_code)
   );

   assign mode_q   = mode_r;
   assign out_en   = out_on;
   assign wake_evt = wake_q;
endmodule

// File: rtl/swsup_ctrl_chk.sv
module swsup_ctrl_chk
   import swsup_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick_us,
   input logic [1:0] mode_q,
   input logic       irq_en,
   input logic       clr_stb,
   input logic       wake_pin,
   input logic       sleep_st,
   input logic       out_en,
   input logic       wake_evt,
   input logic       irq_flag,
   input logic       wake_force,
   input logic [3:0] rsrc_code
);
   assert_off_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00) |-> !out_en);

   assert_on_lit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01) |-> out_en);

   assert_ovl_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> (mode_q == 2'b00 && !out_en));

   assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(irq_en));

   assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !clr_stb) |=> irq_flag);

   assert_force_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_force |-> (rsrc_code == RSRC_SW_LOST && $past(sleep_st) && mode_q == 2'b00));

   assert_wake_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |-> ($past(wake_pin) && $past(tick_us) && $past(mode_q) != 2'b00));
endmodule

bind swsup_ctrl swsup_ctrl_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_us    (tick_us),
   .mode_q     (mode_q),
   .irq_en     (irq_en),
   .clr_stb    (clr_stb),
   .wake_pin   (wake_pin),
   .sleep_st   (sleep_st),
   .out_en     (out_en),
   .wake_evt   (wake_evt),
   .irq_flag   (irq_flag),
   .wake_force (wake_force),
   .rsrc_code  (rsrc_code)
);

// File: tb/swsup_ctrl_tb_top.sv
module swsup_ctrl_tb_top;
   localparam int W  = 4;
   localparam int PA = 16;
   localparam int PB = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_us = 1'b0;
   logic       mode_wr = 1'b0;
   logic [1:0] mode_wdata = 2'b00;
   logic [1:0] mode_q;
   logic       irq_en = 1'b0;
   logic       clr_stb = 1'b0;
   logic       ovl_in = 1'b0;
   logic       wake_pin = 1'b0;
   logic       sleep_st = 1'b0;
   logic       out_en, wake_evt, irq_flag, wake_force;
   logic [3:0] rsrc_code;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   swsup_ctrl #(.ON_WIN(W), .PER_A(PA), .PER_B(PB), .OVL_TICKS(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .mode_wr(mode_wr),
      .mode_wdata(mode_wdata), .mode_q(mode_q), .irq_en(irq_en),
      .clr_stb(clr_stb), .ovl_in(ovl_in), .wake_pin(wake_pin),
      .sleep_st(sleep_st), .out_en(out_en), .wake_evt(wake_evt),
      .irq_flag(irq_flag), .wake_force(wake_force), .rsrc_code(rsrc_code)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   // one clock of stimulus, applied at a falling edge and released at the next
   task automatic cyc(input bit t, input bit ov, input bit wk, input bit wr,
                      input logic [1:0] wd, input bit clr);
      tick_us = t; ovl_in = ov; wake_pin = wk; mode_wr = wr; mode_wdata = wd; clr_stb = clr;
      @(negedge clk);
      tick_us = 0; ovl_in = 0; wake_pin = 0; mode_wr = 0; clr_stb = 0;
   endtask

   task automatic wr(input logic [1:0] m);
      cyc(0, 0, 0, 1, m, 0);
   endtask

   task automatic tk(input bit ov, input bit wk);
      cyc(1, ov, wk, 0, 2'b00, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk_eq("R1 reset mode", mode_q, 0);
      chk_eq("R1 reset out_en", out_en, 0);
      chk_eq("R6 reset irq", irq_flag, 0);
      chk_eq("R7 reset code", rsrc_code, 0);
      chk_eq("R7 reset force", wake_force, 0);

      // R1: On and Off
      wr(2'b01);
      chk_eq("R1 mode On", mode_q, 1);
      chk_eq("R1 out_en On", out_en, 1);
      // R4: every tick samples in On
      for (int k = 0; k < 4; k++) begin
         tk(0, k[0]);
         chk_eq("R4 On sample", wake_evt, k[0]);
      end
      wr(2'b00);
      chk_eq("R1 mode Off", mode_q, 0);
      chk_eq("R1 out_en Off", out_en, 0);
      for (int k = 0; k < 3; k++) begin
         tk(0, 1);
         chk_eq("R4 Off no sample", wake_evt, 0);
      end

      // R2/R4: sweep both cyclic modes over three periods
      for (int m = 2; m < 4; m++) begin
         int p;
         p = (m == 2) ? PA : PB;
         wr(2'(m));
         chk_eq("R1 mode cyclic", mode_q, m);
         for (int k = 0; k < 3 * p; k++) begin
            chk_eq("R2 window", out_en, ((k % p) < W) ? 1 : 0);
            tk(0, 1);
            chk_eq("R4 cyclic sample", wake_evt, ((k % p) == W - 1) ? 1 : 0);
         end
         wr(2'b00);
      end

      // R3: restart rules
      wr(2'b10);
      for (int k = 0; k < 6; k++) tk(0, 0);
      chk_eq("R3 mid period off", out_en, 0);
      wr(2'b10);
      chk_eq("R3 same mode no restart", out_en, 0);
      for (int k = 6; k < PA; k++) tk(0, 0);
      chk_eq("R3 position kept wraps", out_en, 1);
      for (int k = 0; k < 6; k++) tk(0, 0);
      wr(2'b11);
      chk_eq("R3 switch restarts", out_en, 1);
      for (int k = 0; k < 5; k++) tk(0, 0);
      chk_eq("R3 long off", out_en, 0);
      wr(2'b10);
      for (int k = 0; k < W; k++) begin
         chk_eq("R3 restart window", out_en, 1);
         tk(0, 0);
      end
      chk_eq("R3 restart window end", out_en, 0);
      wr(2'b00);

      // R5: filtering
      irq_en = 1;
      wr(2'b01);
      tk(1, 0); tk(0, 0);
      chk_eq("R5 single tick ignored", mode_q, 1);
      tk(1, 0);
      chk_eq("R5 first of two", mode_q, 1);
      tk(1, 0);
      chk_eq("R5 confirmed mode", mode_q, 0);
      chk_eq("R5 confirmed out_en", out_en, 0);
      chk_eq("R6 irq set", irq_flag, 1);
      chk_eq("R7 awake no code", rsrc_code, 0);
      cyc(0, 0, 0, 0, 2'b00, 1);
      chk_eq("R6 irq cleared", irq_flag, 0);
      for (int k = 0; k < 3; k++) tk(1, 0);
      chk_eq("R5 off ignored irq", irq_flag, 0);
      wr(2'b10);
      for (int k = 0; k < W; k++) tk(0, 0);
      tk(1, 0); tk(1, 0); tk(1, 0);
      chk_eq("R5 cyclic off phase ignored", mode_q, 2);
      chk_eq("R5 cyclic off phase irq", irq_flag, 0);
      wr(2'b00);

      // R6: enable gates, set beats clear
      irq_en = 0;
      wr(2'b01);
      tk(1, 0); tk(1, 0);
      chk_eq("R6 disabled no irq", irq_flag, 0);
      chk_eq("R5 disabled still clears", mode_q, 0);
      irq_en = 1;
      wr(2'b01);
      tk(1, 0);
      cyc(1, 1, 0, 0, 2'b00, 1);
      chk_eq("R6 set wins over clear", irq_flag, 1);
      cyc(0, 0, 0, 0, 2'b00, 1);

      // R7: overload during sleep
      sleep_st = 1;
      wr(2'b11);
      tk(1, 0); tk(1, 0);
      chk_eq("R7 force pulse", wake_force, 1);
      chk_eq("R7 code", rsrc_code, 5);
      @(negedge clk);
      chk_eq("R7 force one clock", wake_force, 0);
      chk_eq("R7 code sticky", rsrc_code, 5);
      cyc(0, 0, 0, 0, 2'b00, 1);
      chk_eq("R7 code cleared", rsrc_code, 0);
      sleep_st = 0;
      wr(2'b01);
      tk(1, 0); tk(1, 0);
      chk_eq("R7 awake no force", wake_force, 0);
      chk_eq("R7 awake code zero", rsrc_code, 0);

      // R8: overload and write in the same clock
      wr(2'b01);
      tk(1, 0);
      cyc(1, 1, 0, 1, 2'b11, 0);
      chk_eq("R8 overload beats write", mode_q, 0);
      chk_eq("R8 out_en low", out_en, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule